// File: doc/BRIEF.md
# Abandonable Shift-and-Add Multiplier

This block computes the low word of the product of two 32-bit operands with one multiplier bit per clock. A start pulse captures both operands and the index of the destination register. Over the next 32 cycles the unit adds the shifted multiplicand into a private accumulator whenever the current multiplier bit is set. The unit then presents the result, a destination write-enable and the sign and zero flags for a single cycle.

The accumulator, the shifted operands and the iteration counter are the only state that changes while the multiply runs. The visible result and flags are loaded only at completion. An interrupt-abort input can therefore drop the operation at any iteration and leave the destination register and the flags exactly as they were. The abandoned instruction is later reissued and starts again from its first iteration. Fetching operands, writing the register file and deciding when to abort are handled by the surrounding pipeline.

Top module: `seqmul_abortable`

## Requirements
- R1: A start accepted while idle (start_i high at a rising edge) gives wr_en_o high during the cycle after the 32nd following edge, for exactly one cycle. The unit is idle again one cycle later and accepts a new start at that edge.
- R2: While wr_en_o is high, result_o equals the low 32 bits of op_a_i times op_b_i, as sampled at the accepting edge. Later changes on the operand inputs have no effect.
- R3: While wr_en_o is high, wr_idx_o equals the dst_idx_i value sampled at the accepting edge.
- R4: flag_n_o equals bit 31 of result_o, and flag_z_o is 1 exactly when result_o is all zeros. result_o and both flags change only when a multiply completes.
- R5: abort_i high at the edge of any iteration (1 to 32) abandons the multiply. No wr_en_o pulse follows, result_o and the flags keep their previous values, and the unit is idle at the next edge.
- R6: A start_i pulse during the 32 iterations or during the write cycle is ignored. The running multiply's result and index are unchanged, and no extra write follows.
- R7: A multiply reissued after an abort restarts from its first iteration and gives the correct product 32 iterations later.
- R8: While reset is asserted and after it is released, wr_en_o is 0, result_o is 0, and flag_n_o and flag_z_o are 0.
- R9: abort_i while the unit is idle has no effect on the outputs or on the next multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| start_i | input | 1 | Begin a multiply when idle |
| op_a_i | input | 32 | Multiplicand |
| op_b_i | input | 32 | Multiplier, scanned from bit 0 upward |
| dst_idx_i | input | 4 | Destination register index |
| abort_i | input | 1 | Abandon the running multiply |
| wr_en_o | output | 1 | Destination write-enable and result-valid, one cycle |
| wr_idx_o | output | 4 | Destination register index for the write |
| result_o | output | 32 | Low word of the product |
| flag_n_o | output | 1 | Sign flag of the last completed result |
| flag_z_o | output | 1 | Zero flag of the last completed result |

## Verification
The abort and the final iteration can fall on the same edge. The bench provokes this by raising abort_i exactly at the 32nd iteration. It then requires that no write appears and that result_o and the flags keep the last committed values, so the abort must win over completion. A start pulse can also coincide with a running multiply or with its write cycle. The bench injects a start with different operands and index at both points, and the scoreboard reports any changed product or surplus write.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;
endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
  import seqmul_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  mul_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q;

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    last_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          cnt_d   = CNT_MAX;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (abort_i) begin
          state_d = ST_IDLE;
        end else begin
          step_o = 1'b1;
          cnt_d  = cnt_q - CNT_ONE;
          if (cnt_q == CNT_ONE) begin
            last_o  = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (load_o) begin
      idx_q <= dst_idx_i;
    end
  end

  assign done_o = (state_q == ST_DONE);
  assign idx_o  = idx_q;

  p_abort_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && abort_i) |=> (state_q == ST_IDLE));
  p_last_to_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !abort_i && cnt_q == CNT_ONE) |=> (state_q == ST_DONE));
  p_done_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
  p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> $stable(idx_q));
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/seqmul_datapath.sv
module seqmul_datapath #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic [DATA_W-1:0] prod_o
);
  logic [DATA_W-1:0] mcand_q, mcand_d;
  logic [DATA_W-1:0] mplier_q, mplier_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] acc_sum;
  logic              work_en;

  assign addend  = mplier_q[0] ? mcand_q : '0;
  assign acc_sum = acc_q + addend;
  assign work_en = load_i | step_i;

  // next-state
  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    acc_d    = acc_q;
    if (load_i) begin
      mcand_d  = op_a_i;
      mplier_d = op_b_i;
      acc_d    = '0;
    end else if (step_i) begin
      mcand_d  = {mcand_q[DATA_W-2:0], 1'b0};
      mplier_d = {1'b0, mplier_q[DATA_W-1:1]};
      acc_d    = acc_sum;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (work_en) begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      acc_q    <= acc_d;
    end
  end

  assign prod_o = acc_sum;

  p_load_clears_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (acc_q == '0));
  p_load_takes_ops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (mcand_q == $past(op_a_i) && mplier_q == $past(op_b_i)));
endmodule

// File: rtl/seqmul_commit.sv
module seqmul_commit #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] prod_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_n_o,
  output logic              flag_z_o
);
  logic [DATA_W-1:0] res_q, res_d;
  logic              n_q, n_d;
  logic              z_q, z_d;

  // next-state
  always_comb begin
    res_d = prod_i;
    n_d   = prod_i[DATA_W-1];
    z_d   = (prod_i == '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
    end else if (commit_i) begin
      res_q <= res_d;
      n_q   <= n_d;
      z_q   <= z_d;
    end
  end

  assign wr_en_o  = done_i;
  assign wr_idx_o = idx_i;
  assign result_o = res_q;
  assign flag_n_o = n_q;
  assign flag_z_o = z_q;

  p_commit_then_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> done_i);
  p_flags_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> (flag_n_o == result_o[DATA_W-1]) && (flag_z_o == (result_o == '0)));
  p_write_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/seqmul_abortable.sv
module seqmul_abortable #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic              abort_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_n_o,
  output logic              flag_z_o
);
  logic              load;
  logic              step;
  logic              last;
  logic              done;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] prod;

  seqmul_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .abort_i   (abort_i),
    .dst_idx_i (dst_idx_i),
    .load_o    (load),
    .step_o    (step),
    .last_o    (last),
    .done_o    (done),
    .idx_o     (idx)
  );

  seqmul_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .step_i (step),
    .op_a_i (op_a_i),
    .op_b_i (op_b_i),
    .prod_o (prod)
  );

  seqmul_commit #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_commit (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (last),
    .done_i   (done),
    .prod_i   (prod),
    .idx_i    (idx),
    .wr_en_o  (wr_en_o),
    .wr_idx_o (wr_idx_o),
    .result_o (result_o),
    .flag_n_o (flag_n_o),
    .flag_z_o (flag_z_o)
  );

  p_abort_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !wr_en_o && !load && step == 1'b0 && !done) |=> !wr_en_o);
  p_no_commit_on_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> $stable(result_o) && $stable(flag_n_o) && $stable(flag_z_o));
endmodule

// File: tb/test_seqmul_abortable.sv
`timescale 1ns/1ps
module test_seqmul_abortable;
  typedef struct {
    logic [31:0] res;
    logic [3:0]  idx;
    logic        n;
    logic        z;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] op_a_i;
  logic [31:0] op_b_i;
  logic [3:0]  dst_idx_i;
  logic        abort_i;
  logic        wr_en_o;
  logic [3:0]  wr_idx_o;
  logic [31:0] result_o;
  logic        flag_n_o;
  logic        flag_z_o;

  int checks = 0;
  int fails  = 0;
  exp_t sb[$];
  logic [31:0] last_res = '0;
  logic        last_n   = 1'b0;
  logic        last_z   = 1'b0;

  always #2.5 clk = ~clk;

  seqmul_abortable i_seqmul_abortable (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_a_i(op_a_i),
    .op_b_i(op_b_i), .dst_idx_i(dst_idx_i), .abort_i(abort_i),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .result_o(result_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // monitor: pops expected items when the design writes
  always @(negedge clk) begin
    if (rst_n === 1'b1 && wr_en_o === 1'b1) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R5/R6", "unexpected write", {28'd0, wr_idx_o}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result_o === e.res, "R2", "product", result_o, e.res);
        chk(wr_idx_o === e.idx, "R3", "dest index", {28'd0, wr_idx_o}, {28'd0, e.idx});
        chk(flag_n_o === e.n, "R4", "N flag", {31'd0, flag_n_o}, {31'd0, e.n});
        chk(flag_z_o === e.z, "R4", "Z flag", {31'd0, flag_z_o}, {31'd0, e.z});
        last_res = e.res;
        last_n   = e.n;
        last_z   = e.z;
      end
    end
  end

  // driver: abort_at 0 means run to completion, 1..32 aborts at that iteration
  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] idx, input int abort_at,
                        input bit busy_poke, input bit done_poke);
    exp_t e;
    bit   aborted = 1'b0;
    @(negedge clk);
    start_i   = 1'b1;
    op_a_i    = a;
    op_b_i    = b;
    dst_idx_i = idx;
    if (abort_at == 0) begin
      e.res = a * b;
      e.idx = idx;
      e.n   = e.res[31];
      e.z   = (e.res == 32'd0);
      sb.push_back(e);
    end
    @(negedge clk);
    start_i   = 1'b0;
    op_a_i    = ~a;
    op_b_i    = b ^ 32'h5a5a_0f0f;
    dst_idx_i = ~idx;
    for (int k = 1; k <= 32; k++) begin
      if (k == abort_at) abort_i = 1'b1;
      if (busy_poke && k == 5) begin
        start_i   = 1'b1;
        op_a_i    = $urandom;
        dst_idx_i = idx ^ 4'hf;
      end
      if (k == 32 && abort_at == 0)
        chk(wr_en_o === 1'b0, "R1", "write too early", {31'd0, wr_en_o}, 32'd0);
      @(negedge clk);
      abort_i = 1'b0;
      start_i = 1'b0;
      if (k == abort_at) begin
        aborted = 1'b1;
        break;
      end
    end
    if (aborted) begin
      chk(wr_en_o === 1'b0, "R5", "write after abort", {31'd0, wr_en_o}, 32'd0);
      chk(result_o === last_res, "R5", "result kept", result_o, last_res);
      chk(flag_n_o === last_n && flag_z_o === last_z, "R5", "flags kept",
          {30'd0, flag_n_o, flag_z_o}, {30'd0, last_n, last_z});
    end else begin
      chk(wr_en_o === 1'b1, "R1", "write at iteration 32", {31'd0, wr_en_o}, 32'd1);
      if (done_poke) begin
        start_i   = 1'b1;
        op_a_i    = 32'h1234_5678;
        op_b_i    = 32'h9abc_def1;
        dst_idx_i = idx ^ 4'h3;
      end
      @(negedge clk);
      start_i = 1'b0;
      chk(wr_en_o === 1'b0, "R1", "write lasts one cycle", {31'd0, wr_en_o}, 32'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] corner [4];
    corner[0] = 32'h0000_0000;
    corner[1] = 32'h0000_0001;
    corner[2] = 32'hffff_ffff;
    corner[3] = 32'h8000_0000;
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0;
    op_a_i = '0; op_b_i = '0; dst_idx_i = '0;
    repeat (2) @(negedge clk);
    chk(wr_en_o === 1'b0 && result_o === 32'd0, "R8", "in reset", result_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_en_o === 1'b0, "R8", "write after reset", {31'd0, wr_en_o}, 32'd0);
    chk(result_o === 32'd0, "R8", "result after reset", result_o, 32'd0);
    chk(flag_n_o === 1'b0 && flag_z_o === 1'b0, "R8", "flags after reset",
        {30'd0, flag_n_o, flag_z_o}, 32'd0);

    // R2 R4: corner operand pairs
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        run_op(corner[i], corner[j], 4'(i * 4 + j), 0, 1'b0, 1'b0);

    // R2 R3: random operands
    for (int i = 0; i < 30; i++)
      run_op($urandom, $urandom, 4'($urandom), 0, 1'b0, 1'b0);

    // R5 R7: aborts at random iterations, then reissue from scratch
    for (int i = 0; i < 15; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      logic [3:0]  d = 4'($urandom);
      run_op(a, b, d, $urandom_range(1, 31), 1'b0, 1'b0);
      run_op(a, b, d, 0, 1'b0, 1'b0);
    end

    // R5: abort on the same edge as the final iteration, then reissue (R7)
    run_op(32'hffff_ffff, 32'h8000_0001, 4'h7, 32, 1'b0, 1'b0);
    run_op(32'hffff_ffff, 32'h8000_0001, 4'h7, 0, 1'b0, 1'b0);
    run_op(32'h0000_0003, 32'h0000_0005, 4'h2, 1, 1'b0, 1'b0);
    run_op(32'h0000_0003, 32'h0000_0005, 4'h2, 0, 1'b0, 1'b0);

    // R6: start during iterations and during the write cycle
    for (int i = 0; i < 4; i++)
      run_op($urandom, $urandom, 4'($urandom), 0, 1'b1, 1'b1);
    run_op(32'h8000_0000, 32'h0000_0002, 4'h9, 0, 1'b1, 1'b0);

    // R9: abort while idle
    @(negedge clk);
    abort_i = 1'b1;
    repeat (3) @(negedge clk);
    abort_i = 1'b0;
    chk(wr_en_o === 1'b0, "R9", "idle abort write", {31'd0, wr_en_o}, 32'd0);
    chk(result_o === last_res, "R9", "idle abort result", result_o, last_res);
    run_op(32'h0001_0000, 32'h0001_0000, 4'hc, 0, 1'b0, 1'b0);

    repeat (40) @(negedge clk);
    chk(sb.size() == 0, "R1", "missing writes", 32'(sb.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule